// File: doc/BRIEF.md
# Watchdog Timer with Assignable Prescaler

The block is a free-running watchdog that counts on a slow, separate clock. If software fails to restart it in time, it raises a one-cycle request in the system clock domain. When the core is running, that request is a device reset. When the core is in its low-power state, the request is a wake-up instead. A static configuration input turns the whole watchdog off for good. While that input is set, the block holds a request for the slow oscillator.

An option field chosen by software can place a power-of-two prescaler, from 1:1 to 1:128, in front of the main counter. A restart strobe and a sleep-entry strobe both come from the system domain. Either one returns the counter to zero, and the prescaler too when it is assigned. These strobes cross into the slow domain through a four-phase handshake: a strobe that arrives while an earlier one is still crossing is held and sent after it, not dropped. The block also keeps an active-low time-out flag for software to read. A time-out clears the flag; power-on reset, a restart strobe or a sleep-entry strobe sets it again.

With the default base length of 9 bits and a slow clock of about 31 kHz, the undivided period is roughly 16.5 ms. The full 1:128 prescale stretches this to about 2.1 s.

Top module: `wdog_timer`

## Requirements
- R1: While `rstN` is low and right after it is released, `resetReq` and `wakeReq` are 0 and `toFlagN` is 1.
- R2: `oscRequest` equals `cfgEnable` at all times.
- R3: With `psAssign`=0, a time-out follows a restart strobe after 2^BASE_BITS slow-clock cycles, plus a crossing latency of 2 to 6 slow-clock cycles.
- R4: With `psAssign`=1, the 3-bit field `psRatio` holding value r sets a 1:2^r prescale. The time-out then follows a strobe after 2^(BASE_BITS+r) slow-clock cycles plus the same latency. The prescaler is restarted with the counter.
- R5: Restart strobes spaced closer together than the period prevent any time-out.
- R6: A sleep-entry strobe restarts the counter exactly as a restart strobe does, and it sets `toFlagN` to 1.
- R7: A time-out while `coreAsleep`=0 produces a `resetReq` pulse exactly one system cycle long.
- R8: A time-out while `coreAsleep`=1 produces a one-cycle `wakeReq` pulse and no `resetReq`.
- R9: While `cfgEnable`=0 the counter is held, and neither `resetReq` nor `wakeReq` is ever raised.
- R10: `toFlagN` goes to 0 in the same cycle as a `resetReq` or `wakeReq` pulse. A restart or sleep-entry strobe sets it to 1 one cycle later. If both happen in the same cycle, the time-out wins.
- R11: A strobe issued while an earlier strobe's handshake is still in progress is not lost. The time-out is measured from the later strobe.
- R12: `resetReq` and `wakeReq` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock |
| wdClk | input | 1 | Slow watchdog clock |
| rstN | input | 1 | Asynchronous power-on reset, active low, for both domains |
| cfgEnable | input | 1 | Static configuration enable |
| psAssign | input | 1 | Option field: prescaler assigned to the watchdog |
| psRatio | input | 3 | Option field: prescale exponent r, ratio 1:2^r |
| clrStrobe | input | 1 | Restart strobe, one system cycle |
| sleepStrobe | input | 1 | Sleep-entry strobe, one system cycle |
| coreAsleep | input | 1 | Core is in its low-power state |
| oscRequest | output | 1 | Request that keeps the slow oscillator running |
| resetReq | output | 1 | Device reset request pulse |
| wakeReq | output | 1 | Wake-up request pulse |
| toFlagN | output | 1 | Active-low time-out status flag |

## Verification
The bench restarts the counter at an arbitrary prescaler phase with ratios 1, 3 and 7. It then times the gap to the time-out in slow-clock edges. A design that failed to clear the prescaler on restart would fire up to 2^r-1 edges early and miss the window. A second strobe is sent while the first strobe's handshake is still in flight. A design that dropped it would time out measured from the first strobe, and that lands below the lower bound. The bench also checks three more cases. In the sleep case, a design that routed the time-out wrongly would raise a reset instead of a wake-up. With the watchdog disabled, it waits three periods, where a leaky enable would still fire. Finally, it checks that the flag is set again by either strobe.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Width of the prescale exponent field and the prescaler stage count it implies
  localparam int PS_SEL_W = 3;
  localparam int PS_W     = (1 << PS_SEL_W) - 1;

  // Control strobes and option bits sent from the system side to the counter side
  typedef struct packed {
    logic                clrReq;
    logic                enable;
    logic                psAssign;
    logic [PS_SEL_W-1:0] psRatio;
  } wdCtl_t;

  // Status returned from the counter side
  typedef struct packed {
    logic clrAck;
    logic toToggle;
  } wdStat_t;
endpackage

// File: rtl/wdog_sync.sv
module wdog_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[i] <= '0;
      else       stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int BASE_BITS = 9
) (
  input  logic    wdClk,
  input  logic    rstN,
  input  wdCtl_t  ctlAsync,
  output wdStat_t stat
);
  localparam int CTL_W = $bits(wdCtl_t);
  localparam logic [BASE_BITS-1:0] BASE_MAX = '1;

  logic [CTL_W-1:0]     ctlVec;
  wdCtl_t               ctlS;
  logic                 reqPrev;
  logic                 clearEv;
  logic [PS_W-1:0]      psCnt;
  logic [PS_W-1:0]      psMask;
  logic                 tick;
  logic [BASE_BITS-1:0] baseCnt;
  logic                 toTgl;

  wdog_sync #(.W(CTL_W), .STAGES(2)) ctlSync_i (
    .clk (wdClk),
    .rstN(rstN),
    .d   (ctlAsync),
    .q   (ctlVec)
  );
  assign ctlS = wdCtl_t'(ctlVec);

  // A rising request edge is one restart; the acknowledge follows the request
  assign clearEv = ctlS.clrReq & ~reqPrev;
  assign psMask  = PS_W'((32'd1 << ctlS.psRatio) - 32'd1);
  assign tick    = ~ctlS.psAssign | ((psCnt & psMask) == psMask);

  always_ff @(posedge wdClk or negedge rstN) begin
    if (!rstN) begin
      reqPrev <= 1'b0;
      psCnt   <= '0;
      baseCnt <= '0;
      toTgl   <= 1'b0;
    end else begin
      reqPrev <= ctlS.clrReq;
      if (!ctlS.enable) begin
        psCnt   <= '0;
        baseCnt <= '0;
      end else if (clearEv) begin
        baseCnt <= '0;
        psCnt   <= ctlS.psAssign ? '0 : psCnt + 1'b1;
      end else begin
        psCnt <= psCnt + 1'b1;
        if (tick) begin
          baseCnt <= baseCnt + 1'b1;
          if (baseCnt == BASE_MAX) toTgl <= ~toTgl;
        end
      end
    end
  end

  assign stat = '{clrAck: reqPrev, toToggle: toTgl};
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                cfgEnable,
  input  logic                psAssign,
  input  logic [PS_SEL_W-1:0] psRatio,
  input  logic                clrStrobe,
  input  logic                sleepStrobe,
  input  logic                coreAsleep,
  input  wdStat_t             statAsync,
  output wdCtl_t              ctl,
  output logic                resetReq,
  output logic                wakeReq,
  output logic                toFlagN
);
  logic [1:0] statVec;
  wdStat_t    statS;
  logic       toPrev;
  logic       toPulse;
  logic       anyStrobe;
  logic       pending;
  logic       req;
  logic       launch;

  wdog_sync #(.W(2), .STAGES(2)) statSync_i (
    .clk (sysClk),
    .rstN(rstN),
    .d   (statAsync),
    .q   (statVec)
  );
  assign statS = wdStat_t'(statVec);

  assign toPulse   = (statS.toToggle ^ toPrev) & cfgEnable;
  assign anyStrobe = clrStrobe | sleepStrobe;
  // A new request may start only when the previous four-phase cycle has closed
  assign launch    = (pending | anyStrobe) & ~req & ~statS.clrAck;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      toPrev   <= 1'b0;
      pending  <= 1'b0;
      req      <= 1'b0;
      resetReq <= 1'b0;
      wakeReq  <= 1'b0;
      toFlagN  <= 1'b1;
    end else begin
      toPrev   <= statS.toToggle;
      pending  <= (pending | anyStrobe) & ~launch;
      if (launch)                 req <= 1'b1;
      else if (req & statS.clrAck) req <= 1'b0;
      resetReq <= toPulse & ~coreAsleep;
      wakeReq  <= toPulse & coreAsleep;
      if (toPulse)        toFlagN <= 1'b0;
      else if (anyStrobe) toFlagN <= 1'b1;
    end
  end

  assign ctl = '{clrReq: req, enable: cfgEnable, psAssign: psAssign, psRatio: psRatio};
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int BASE_BITS = 9
) (
  input  logic                sysClk,
  input  logic                wdClk,
  input  logic                rstN,
  input  logic                cfgEnable,
  input  logic                psAssign,
  input  logic [PS_SEL_W-1:0] psRatio,
  input  logic                clrStrobe,
  input  logic                sleepStrobe,
  input  logic                coreAsleep,
  output logic                oscRequest,
  output logic                resetReq,
  output logic                wakeReq,
  output logic                toFlagN
);
  wdCtl_t  ctlBus;
  wdStat_t statBus;

  assign oscRequest = cfgEnable;

  wdog_ctrl ctrl_i (
    .sysClk     (sysClk),
    .rstN       (rstN),
    .cfgEnable  (cfgEnable),
    .psAssign   (psAssign),
    .psRatio    (psRatio),
    .clrStrobe  (clrStrobe),
    .sleepStrobe(sleepStrobe),
    .coreAsleep (coreAsleep),
    .statAsync  (statBus),
    .ctl        (ctlBus),
    .resetReq   (resetReq),
    .wakeReq    (wakeReq),
    .toFlagN    (toFlagN)
  );

  wdog_dp #(.BASE_BITS(BASE_BITS)) dp_i (
    .wdClk   (wdClk),
    .rstN    (rstN),
    .ctlAsync(ctlBus),
    .stat    (statBus)
  );
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic sysClk,
  input logic rstN,
  input logic cfgEnable,
  input logic clrStrobe,
  input logic sleepStrobe,
  input logic coreAsleep,
  input logic oscRequest,
  input logic resetReq,
  input logic wakeReq,
  input logic toFlagN
);
  // R2
  osc_follow_chk: assert property (@(posedge sysClk) oscRequest == cfgEnable);

  // R12
  req_excl_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    !(resetReq && wakeReq));

  // R7
  reset_single_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    resetReq |=> !resetReq);

  // R8
  wake_single_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    wakeReq |=> !wakeReq);

  // R8
  wake_asleep_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    wakeReq |-> $past(coreAsleep));

  // R7
  reset_awake_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    resetReq |-> !$past(coreAsleep));

  // R9
  disabled_quiet_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (resetReq || wakeReq) |-> $past(cfgEnable));

  // R10
  flag_low_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    (resetReq || wakeReq) |-> !toFlagN);

  // R10
  flag_set_chk: assert property (@(posedge sysClk) disable iff (!rstN)
    ($past(clrStrobe || sleepStrobe) && !resetReq && !wakeReq) |-> toFlagN);
endmodule

bind wdog_timer wdog_timer_chk chk_i (
  .sysClk     (sysClk),
  .rstN       (rstN),
  .cfgEnable  (cfgEnable),
  .clrStrobe  (clrStrobe),
  .sleepStrobe(sleepStrobe),
  .coreAsleep (coreAsleep),
  .oscRequest (oscRequest),
  .resetReq   (resetReq),
  .wakeReq    (wakeReq),
  .toFlagN    (toFlagN)
);

// File: tb/wdog_timer_tb_top.sv
`timescale 1ns/1ps
module wdog_timer_tb_top;
  localparam int BASE = 4;
  localparam int PER0 = 1 << BASE;

  logic       sysClk = 1'b0;
  logic       wdClk  = 1'b0;
  logic       rstN   = 1'b0;
  logic       cfgEnable = 1'b1;
  logic       psAssign  = 1'b0;
  logic [2:0] psRatio   = 3'd0;
  logic       clrStrobe = 1'b0;
  logic       sleepStrobe = 1'b0;
  logic       coreAsleep  = 1'b0;
  logic       oscRequest, resetReq, wakeReq, toFlagN;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int wdCnt  = 0;
  int rstCnt = 0;
  int wakeCnt = 0;
  int lastEvAt = 0;

  always #4  sysClk = ~sysClk;   // 125 MHz
  always #34 wdClk  = ~wdClk;

  wdog_timer #(.BASE_BITS(BASE)) dut_i (
    .sysClk(sysClk), .wdClk(wdClk), .rstN(rstN), .cfgEnable(cfgEnable),
    .psAssign(psAssign), .psRatio(psRatio), .clrStrobe(clrStrobe),
    .sleepStrobe(sleepStrobe), .coreAsleep(coreAsleep), .oscRequest(oscRequest),
    .resetReq(resetReq), .wakeReq(wakeReq), .toFlagN(toFlagN)
  );

  always @(posedge wdClk) wdCnt <= wdCnt + 1;

  // Behavioural observer of the request pulses, timestamped in slow-clock edges
  always @(negedge sysClk) begin
    if (resetReq) begin rstCnt++;  lastEvAt = wdCnt; end
    if (wakeReq)  begin wakeCnt++; lastEvAt = wdCnt; end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic strobe(input bit slp, output int at);
    @(posedge sysClk); #1;
    if (slp) sleepStrobe = 1'b1; else clrStrobe = 1'b1;
    at = wdCnt;
    @(posedge sysClk); #1;
    sleepStrobe = 1'b0; clrStrobe = 1'b0;
  endtask

  task automatic expectEvent(input string tag, input bit wake, input int at,
                             input int per, input int lo, input int hi);
    int r0, w0, dt;
    bit got;
    r0 = rstCnt; w0 = wakeCnt;
    while (rstCnt == r0 && wakeCnt == w0 && wdCnt < at + per + hi + 3)
      @(negedge sysClk);
    got = wake ? (wakeCnt != w0) : (rstCnt != r0);
    chk(got, tag, wake ? "wake pulse seen" : "reset pulse seen", int'(got), 1);
    chk(wake ? (rstCnt == r0) : (wakeCnt == w0), tag, "other request silent",
        wake ? rstCnt - r0 : wakeCnt - w0, 0);
    dt = lastEvAt - at;
    chk(got && dt >= per + lo && dt <= per + hi, tag, "time-out delay in slow edges",
        dt, per + lo);
    chk(toFlagN == 1'b0, "R10", "flag low after time-out", int'(toFlagN), 0);
  endtask

  task automatic waitWd(input int n);
    repeat (n) @(posedge wdClk);
    @(negedge sysClk);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      finishRun();
    end
  end

  initial begin
    int at, at2, r0, w0;
    repeat (5) @(negedge sysClk);
    // R1 reset state
    chk(resetReq == 0 && wakeReq == 0, "R1", "requests low in reset", int'(resetReq | wakeReq), 0);
    chk(toFlagN == 1'b1, "R1", "flag high in reset", int'(toFlagN), 1);
    chk(oscRequest == 1'b1, "R2", "oscillator request with enable set", int'(oscRequest), 1);
    @(posedge sysClk); #1 rstN = 1'b1;
    @(negedge sysClk);
    chk(resetReq == 0 && wakeReq == 0 && toFlagN == 1, "R1", "state after release",
        int'({resetReq, wakeReq, toFlagN}), 1);

    // R3 and R7: undivided period, awake
    strobe(1'b0, at);
    expectEvent("R3", 1'b0, at, PER0, 2, 6);
    @(negedge sysClk);
    chk(resetReq == 1'b0, "R7", "reset pulse one cycle", int'(resetReq), 0);

    // R10: restart strobe sets the flag
    strobe(1'b0, at);
    @(negedge sysClk);
    chk(toFlagN == 1'b1, "R10", "flag set by restart strobe", int'(toFlagN), 1);

    // R5: periodic restarts prevent any time-out
    r0 = rstCnt; w0 = wakeCnt;
    for (int k = 0; k < 6; k++) begin
      waitWd(PER0 - 6);
      strobe(1'b0, at);
    end
    chk(rstCnt == r0 && wakeCnt == w0, "R5", "no time-out while restarted",
        rstCnt - r0 + wakeCnt - w0, 0);
    expectEvent("R5", 1'b0, at, PER0, 2, 6);

    // R4: prescaler ratios, restarted at an arbitrary prescaler phase
    psAssign = 1'b1;
    foreach (psRatio[i]) ;
    for (int s = 0; s < 3; s++) begin
      int r;
      r = (s == 0) ? 1 : (s == 1) ? 3 : 7;
      psRatio = 3'(r);
      waitWd(3 + s);
      repeat (3) @(negedge sysClk);
      strobe(1'b0, at);
      expectEvent("R4", 1'b0, at, PER0 << r, 2, 6);
    end
    psAssign = 1'b0; psRatio = 3'd0;
    waitWd(3);

    // R6: sleep-entry strobe restarts the counter while awake
    strobe(1'b1, at);
    expectEvent("R6", 1'b0, at, PER0, 2, 6);

    // R8: time-out while asleep gives a wake-up, not a reset
    coreAsleep = 1'b1;
    strobe(1'b1, at);
    @(negedge sysClk);
    chk(toFlagN == 1'b1, "R6", "flag set by sleep-entry strobe", int'(toFlagN), 1);
    expectEvent("R8", 1'b1, at, PER0, 2, 6);
    @(negedge sysClk);
    chk(wakeReq == 1'b0, "R8", "wake pulse one cycle", int'(wakeReq), 0);
    coreAsleep = 1'b0;

    // R11: second strobe during the first one's handshake is not lost
    strobe(1'b0, at);
    repeat (4) @(posedge wdClk);
    strobe(1'b0, at2);
    expectEvent("R11", 1'b0, at2, PER0, 2, 12);

    // R9: disabled watchdog stays quiet
    cfgEnable = 1'b0;
    @(negedge sysClk);
    chk(oscRequest == 1'b0, "R2", "oscillator request dropped", int'(oscRequest), 1'b0);
    r0 = rstCnt; w0 = wakeCnt;
    waitWd(3 * PER0);
    chk(rstCnt == r0 && wakeCnt == w0, "R9", "no request while disabled",
        rstCnt - r0 + wakeCnt - w0, 0);
    cfgEnable = 1'b1;
    waitWd(3);
    strobe(1'b0, at);
    expectEvent("R9", 1'b0, at, PER0, 2, 6);

    finishRun();
  end
endmodule